// File: doc/BRIEF.md
# Prioritised Backplane Interrupter with Vector

This block is the requester side of a seven-level, daisy-chained interrupt scheme on an asynchronous backplane. A local event raises a request on the level chosen by configuration. The handler then runs an acknowledge cycle and places the level it is serving on the three low address lines. When the chain input reaches this module, the block does one of two things. If it has a request pending on that level, it drives its configured 8-bit vector on the low data byte and acknowledges. If not, it passes the chain on to the next slot, so the slot nearest the start of the chain wins among requesters on the same level.

Two clearing rules are selectable. In acknowledge-release mode, finishing the acknowledge cycle drops the request. In access-release mode, the request outlives the acknowledge cycle and is removed only by a pulse on a separate register-access input. All bus inputs are assumed already synchronised to `clk` and converted to active-high polarity at the pads. Outputs are active high as well. A request is identified to the handler by the single set bit of `irq_o`, where bit i stands for level i+1.

Top module: `bus_interrupter`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), irq_o is all zero and iack_out_o, dtack_o and data_oe_o are low.
- R2: A one-cycle event_i pulse with cfg_level_i = L in 1..7 sets exactly irq_o bit L-1 from the following clock edge. No other bit is set.
- R3: An acknowledge cycle has iack_i, as_i, ds_i and iack_in_i high together. If a request is pending and addr_lvl_i equals cfg_level_i, then from the next edge dtack_o and data_oe_o are high, data_o carries cfg_vector_i, and iack_out_o stays low.
- R4: An acknowledge cycle whose addr_lvl_i differs from cfg_level_i drives iack_out_o high from the next edge, with dtack_o and data_oe_o kept low.
- R5: An acknowledge cycle that reaches the module with no request pending passes the chain: iack_out_o goes high and dtack_o stays low.
- R6: In acknowledge-release mode (cfg_rora_i = 0), ds_i dropping during the response clears the request at the next edge. dtack_o and data_oe_o fall at that same edge.
- R7: In access-release mode (cfg_rora_i = 1), the request survives the acknowledge cycle. A one-cycle reg_access_i pulse clears it at the next edge.
- R8: iack_out_o falls in the same cycle that as_i falls, without waiting for a clock edge.
- R9: Further events while a request is pending are merged. A single acknowledge in acknowledge-release mode leaves no request behind.
- R10: With cfg_level_i = 0, event_i raises no request.
- R11: Without iack_in_i, or without iack_i, a strobed cycle on the matching level produces neither dtack_o nor iack_out_o.
- R12: In acknowledge-release mode, reg_access_i has no effect on a pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_level_i | input | 3 | Request level, 1..7; 0 disables |
| cfg_vector_i | input | 8 | Vector returned on acknowledge |
| cfg_rora_i | input | 1 | 1 = access-release, 0 = acknowledge-release |
| event_i | input | 1 | Local interrupt event pulse |
| reg_access_i | input | 1 | Clearing register access pulse |
| as_i | input | 1 | Address strobe |
| ds_i | input | 1 | Data strobe |
| iack_i | input | 1 | Acknowledge-cycle marker line |
| iack_in_i | input | 1 | Acknowledge chain input |
| addr_lvl_i | input | 3 | Level code from address lines 1..3 |
| irq_o | output | 7 | Request lines, bit i = level i+1 |
| iack_out_o | output | 1 | Acknowledge chain output |
| dtack_o | output | 1 | Data acknowledge |
| data_o | output | 8 | Vector byte |
| data_oe_o | output | 1 | Enable for the vector byte |

## Verification
The assertions take for granted that the configuration inputs hold still for as long as a request is pending or an acknowledge cycle is in progress. They also assume that addr_lvl_i and iack_in_i stay stable while as_i is high, and that ds_i falls no later than as_i. The bench changes the level, vector and mode only between cycles, while nothing is pending or after a reset. Every strobe and chain transition is driven on the falling clock edge, following the ordering the handler uses, so these assumptions are never broken.

// File: rtl/irq_pkg.sv
// Shared types and sizes for the backplane interrupter.
package irq_pkg;
    localparam int unsigned NUM_LEVELS = 7;
    localparam int unsigned LVL_W      = 3;
    localparam int unsigned VEC_W      = 8;

    typedef enum logic [1:0] {
        ACK_IDLE = 2'd0,
        ACK_PASS = 2'd1,
        ACK_RESP = 2'd2,
        ACK_DONE = 2'd3
    } ack_state_t;
endpackage

// File: rtl/irq_pending.sv
// Request holder. Keeps one pending flag, merges repeated events, and
// clears the flag by the rule the mode selects. Drives the one-hot
// request lines. Assumes level and mode are stable while pending.
module irq_pending #(
    parameter int unsigned LEVELS = 7,
    parameter int unsigned LW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              event_i,
    input  logic              ack_done_i,
    input  logic              reg_clr_i,
    input  logic              rora_i,
    input  logic [LW-1:0]     level_i,
    output logic              pending_o,
    output logic [LEVELS-1:0] irq_o
);
    logic pend_q;
    logic level_ok;
    logic release_now;

    assign level_ok    = (level_i != '0) && (32'(level_i) <= LEVELS);
    assign release_now = rora_i ? reg_clr_i : ack_done_i;

    // Pending flag: set by an event on a valid level, cleared by release.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= (pend_q && !release_now) || (event_i && level_ok);
    end

    assign pending_o = pend_q;

    // One request line per level, driven when that level is programmed.
    for (genvar g = 0; g < LEVELS; g++) begin : g_line
        assign irq_o[g] = pend_q && (32'(level_i) == g + 1);
    end

    // R2: at most one request line at any time.
    a_r2_irq_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_o));
    // R6: acknowledge completion in release-on-ack mode drops the request.
    a_r6_roak_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_done_i && !rora_i && !event_i) |=> !pend_q);
    // R7: in access-release mode only the register access clears it.
    a_r7_rora_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && rora_i && !reg_clr_i) |=> pend_q);
    // R12: register access ignored in acknowledge-release mode.
    a_r12_access_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !rora_i && !ack_done_i) |=> pend_q);
endmodule

// File: rtl/iack_chain_fsm.sv
// Acknowledge-cycle tracker. At the start of a qualified acknowledge
// cycle it decides between responding and passing the chain on, then
// follows the strobes back to idle. Assumes ds falls no later than as.
module iack_chain_fsm #(
    parameter int unsigned LW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          as_i,
    input  logic          ds_i,
    input  logic          iack_i,
    input  logic          iack_in_i,
    input  logic [LW-1:0] addr_lvl_i,
    input  logic [LW-1:0] level_i,
    input  logic          pending_i,
    output logic          start_resp_o,
    output logic          resp_o,
    output logic          pass_o,
    output logic          ack_done_o
);
    import irq_pkg::*;

    ack_state_t state_q, state_d;
    logic       cycle_start;
    logic       hit;

    assign cycle_start  = as_i && ds_i && iack_i && iack_in_i;
    assign hit          = pending_i && (addr_lvl_i == level_i);
    assign start_resp_o = (state_q == ACK_IDLE) && cycle_start && hit;

    // Next-state selection for the acknowledge handshake.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACK_IDLE: if (cycle_start) state_d = hit ? ACK_RESP : ACK_PASS;
            ACK_PASS: if (!as_i)       state_d = ACK_IDLE;
            ACK_RESP: if (!as_i)       state_d = ACK_IDLE;
                      else if (!ds_i)  state_d = ACK_DONE;
            ACK_DONE: if (!as_i)       state_d = ACK_IDLE;
            default:                   state_d = ACK_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ACK_IDLE;
        else        state_q <= state_d;
    end

    assign resp_o     = (state_q == ACK_RESP);
    assign pass_o     = (state_q == ACK_PASS) && as_i;
    assign ack_done_o = (state_q == ACK_RESP) && !ds_i;

    // R4/R5: a qualified cycle without a hit passes the chain next cycle.
    a_r4_pass_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ACK_IDLE && cycle_start && !hit && as_i) |=> pass_o);
    // R3: a response only starts with a pending request on the served level.
    a_r3_resp_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resp_o) |-> $past(pending_i) && ($past(addr_lvl_i) == $past(level_i)));
    // R11: no response or pass without the chain input and acknowledge line.
    a_r11_needs_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ACK_IDLE && !(iack_i && iack_in_i)) |=> (!resp_o && state_q != ACK_PASS));
endmodule

// File: rtl/vector_drv.sv
// Vector output stage. Captures the configured vector when a response
// starts and presents it, with its enable, for the response only.
module vector_drv #(
    parameter int unsigned VW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [VW-1:0] vector_i,
    input  logic          resp_i,
    output logic [VW-1:0] data_o,
    output logic          oe_o
);
    logic [VW-1:0] vec_q;

    // Capture register for the vector at response start.
    always_ff @(posedge clk) begin
        if (!rst_n)      vec_q <= '0;
        else if (load_i) vec_q <= vector_i;
    end

    assign data_o = resp_i ? vec_q : '0;
    assign oe_o   = resp_i;

    // R3: the vector byte holds steady throughout a response.
    a_r3_vector_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_i && $past(resp_i)) |-> $stable(data_o));
endmodule

// File: rtl/bus_interrupter.sv
// Top of the prioritised interrupter: request holder, acknowledge
// chain tracker and vector driver. Inputs are synchronous, active high.
module bus_interrupter #(
    parameter int unsigned LEVELS = irq_pkg::NUM_LEVELS,
    parameter int unsigned LW     = irq_pkg::LVL_W,
    parameter int unsigned VW     = irq_pkg::VEC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LW-1:0]     cfg_level_i,
    input  logic [VW-1:0]     cfg_vector_i,
    input  logic              cfg_rora_i,
    input  logic              event_i,
    input  logic              reg_access_i,
    input  logic              as_i,
    input  logic              ds_i,
    input  logic              iack_i,
    input  logic              iack_in_i,
    input  logic [LW-1:0]     addr_lvl_i,
    output logic [LEVELS-1:0] irq_o,
    output logic              iack_out_o,
    output logic              dtack_o,
    output logic [VW-1:0]     data_o,
    output logic              data_oe_o
);
    logic pending;
    logic start_resp;
    logic resp;
    logic pass;
    logic ack_done;

    irq_pending #(.LEVELS(LEVELS), .LW(LW)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .event_i    (event_i),
        .ack_done_i (ack_done),
        .reg_clr_i  (reg_access_i),
        .rora_i     (cfg_rora_i),
        .level_i    (cfg_level_i),
        .pending_o  (pending),
        .irq_o      (irq_o)
    );

    iack_chain_fsm #(.LW(LW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .as_i         (as_i),
        .ds_i         (ds_i),
        .iack_i       (iack_i),
        .iack_in_i    (iack_in_i),
        .addr_lvl_i   (addr_lvl_i),
        .level_i      (cfg_level_i),
        .pending_i    (pending),
        .start_resp_o (start_resp),
        .resp_o       (resp),
        .pass_o       (pass),
        .ack_done_o   (ack_done)
    );

    vector_drv #(.VW(VW)) u_vec (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (start_resp),
        .vector_i (cfg_vector_i),
        .resp_i   (resp),
        .data_o   (data_o),
        .oe_o     (data_oe_o)
    );

    assign iack_out_o = pass;
    assign dtack_o    = resp;

    // R8: the chain output never stays up once the address strobe is gone.
    a_r8_chain_release: assert property (@(posedge clk) disable iff (!rst_n)
        !as_i |-> !iack_out_o);
    // R3: a response never coexists with the chain being passed.
    a_r3_resp_or_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !(dtack_o && iack_out_o));
endmodule

// File: tb/tb_bus_interrupter.sv
module tb_bus_interrupter;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] cfg_level;
    logic [7:0] cfg_vector;
    logic       cfg_rora;
    logic       ev, regacc, as_s, ds_s, iack, iack_in;
    logic [2:0] alvl;
    logic [6:0] irq;
    logic       iack_out, dtack, data_oe;
    logic [7:0] data;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    bus_interrupter dut (
        .clk(clk), .rst_n(rst_n), .cfg_level_i(cfg_level), .cfg_vector_i(cfg_vector),
        .cfg_rora_i(cfg_rora), .event_i(ev), .reg_access_i(regacc), .as_i(as_s),
        .ds_i(ds_s), .iack_i(iack), .iack_in_i(iack_in), .addr_lvl_i(alvl),
        .irq_o(irq), .iack_out_o(iack_out), .dtack_o(dtack), .data_o(data),
        .data_oe_o(data_oe)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] lvl, input logic [7:0] vec, input logic rora);
        @(negedge clk);
        rst_n = 1'b0; cfg_level = lvl; cfg_vector = vec; cfg_rora = rora;
        ev = 0; regacc = 0; as_s = 0; ds_s = 0; iack = 0; iack_in = 0; alvl = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_event();
        ev = 1'b1; @(negedge clk); ev = 1'b0;
    endtask

    task automatic pulse_access();
        regacc = 1'b1; @(negedge clk); regacc = 1'b0;
    endtask

    task automatic start_ack(input logic [2:0] lvl, input logic chain, input logic ack_line);
        as_s = 1; ds_s = 1; iack = ack_line; iack_in = chain; alvl = lvl;
        @(negedge clk);
    endtask

    task automatic end_ack();
        ds_s = 0; @(negedge clk);
        as_s = 0; iack = 0; iack_in = 0; @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset(3'd3, 8'h5A, 1'b0);
        check("R1 irq", irq, 0);
        check("R1 iack_out", iack_out, 0);
        check("R1 dtack", dtack, 0);
        check("R1 data_oe", data_oe, 0);
    endtask

    task automatic t_raise_levels();
        for (int l = 1; l <= 7; l++) begin
            do_reset(3'(l), 8'h10, 1'b0);
            pulse_event();
            check("R2 irq line", irq, 1 << (l - 1));
        end
    endtask

    task automatic t_match_roak();
        do_reset(3'd5, 8'hC3, 1'b0);
        pulse_event();
        start_ack(3'd5, 1'b1, 1'b1);
        check("R3 dtack", dtack, 1);
        check("R3 data_oe", data_oe, 1);
        check("R3 vector", data, 8'hC3);
        check("R3 no pass", iack_out, 0);
        ds_s = 0; @(negedge clk);
        check("R6 irq cleared", irq, 0);
        check("R6 dtack low", dtack, 0);
        as_s = 0; iack = 0; iack_in = 0; @(negedge clk);
    endtask

    task automatic t_mismatch();
        do_reset(3'd2, 8'h21, 1'b0);
        pulse_event();
        start_ack(3'd4, 1'b1, 1'b1);
        check("R4 pass", iack_out, 1);
        check("R4 no dtack", dtack, 0);
        check("R4 no data_oe", data_oe, 0);
        ds_s = 0; @(negedge clk);
        as_s = 0; #1;
        check("R8 chain released", iack_out, 0);
        iack = 0; iack_in = 0; @(negedge clk);
        check("R4 request kept", irq, 7'b0000010);
    endtask

    task automatic t_no_pending();
        do_reset(3'd6, 8'h66, 1'b0);
        start_ack(3'd6, 1'b1, 1'b1);
        check("R5 pass", iack_out, 1);
        check("R5 no dtack", dtack, 0);
        end_ack();
    endtask

    task automatic t_rora();
        do_reset(3'd7, 8'hE7, 1'b1);
        pulse_event();
        start_ack(3'd7, 1'b1, 1'b1);
        check("R7 vector", data, 8'hE7);
        end_ack();
        check("R7 still pending", irq, 7'b1000000);
        pulse_access();
        check("R7 cleared", irq, 0);
    endtask

    task automatic t_merge();
        do_reset(3'd1, 8'h01, 1'b0);
        pulse_event();
        pulse_event();
        pulse_event();
        check("R9 single line", irq, 7'b0000001);
        start_ack(3'd1, 1'b1, 1'b1);
        end_ack();
        check("R9 nothing left", irq, 0);
        start_ack(3'd1, 1'b1, 1'b1);
        check("R9 next cycle passes", iack_out, 1);
        end_ack();
    endtask

    task automatic t_level0();
        do_reset(3'd0, 8'h77, 1'b0);
        pulse_event();
        check("R10 no request", irq, 0);
    endtask

    task automatic t_no_chain();
        do_reset(3'd3, 8'h33, 1'b0);
        pulse_event();
        start_ack(3'd3, 1'b0, 1'b1);
        check("R11 no dtack without chain", dtack, 0);
        check("R11 no pass without chain", iack_out, 0);
        end_ack();
        start_ack(3'd3, 1'b1, 1'b0);
        check("R11 no dtack without ack line", dtack, 0);
        check("R11 no pass without ack line", iack_out, 0);
        end_ack();
        check("R11 request kept", irq, 7'b0000100);
    endtask

    task automatic t_access_ignored();
        do_reset(3'd4, 8'h44, 1'b0);
        pulse_event();
        pulse_access();
        check("R12 request kept", irq, 7'b0001000);
    endtask

    initial begin
        rst_n = 1'b0;
        t_reset();
        t_raise_levels();
        t_match_roak();
        t_mismatch();
        t_no_pending();
        t_rora();
        t_merge();
        t_level0();
        t_no_chain();
        t_access_ignored();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule